// File: doc/BRIEF.md
# Three-Read Replicated Register File

This block is a 512-word by 32-bit register file that serves three reads and one write in every clock cycle. The storage primitive it is built from offers only one read port and one write port, so the file holds three identical copies of the whole array, one behind each read port. Every accepted write is broadcast to all three copies in the same cycle with the same address and data, so the copies never drift apart and each read port may address any word on any cycle, regardless of what the other ports or the write port are doing.

The three read ports are meant for a processor core that fetches an instruction word, a source operand and a destination operand in one cycle, allowing one instruction to issue per clock. Reads are synchronous: an address presented before a rising edge yields its data just after that edge. When a read and a write hit the same word in the same cycle, the read returns the word being written, so a core can write a result and read it back without a stall.

After reset the block clears itself: an internal sweep writes zero into every word of all three copies, one word per cycle, and raises `ready` when it is finished. The external write port is ignored until then.

Top module: `rf_tri_read`

## Requirements
- R1: While reset (`rstN` low, synchronous) is asserted `ready` is 0; after release `ready` rises exactly DEPTH (512) rising edges later and then stays 1 until the next reset.
- R2: Once `ready` is 1, every word that has not been written since reset reads as zero on all three ports.
- R3: Writes presented while `ready` is 0 are discarded; the addressed word still reads zero afterwards.
- R4: When `ready` is 1 and `wrEn` is 1 at a rising edge, `wrData` is stored at `wrAddr` and is then returned by any of the three read ports that addresses that word.
- R5: Each read port has one clock of latency: the data output after a rising edge is the content of the word whose address was on that port at that edge, and it holds until the next edge.
- R6: The three read ports are independent: in one cycle they may address three different words and each returns its own word.
- R7: If a read port's address equals `wrAddr` at an edge where a write is accepted, that port returns the new `wrData` after the edge (same-cycle bypass), on each of the three ports.
- R8: With `wrEn` at 0 nothing is stored, whatever `wrAddr` and `wrData` hold.
- R9: The three copies stay identical: any ports that address the same word at the same edge return the same value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, all activity on the rising edge |
| rstN | input | 1 | Synchronous active-low reset, starts the clearing sweep |
| ready | output | 1 | High once the clearing sweep is finished |
| wrEn | input | 1 | Write enable, honoured only while `ready` is high |
| wrAddr | input | 9 | Word address of the write |
| wrData | input | 32 | Data to write to all copies |
| fetchAddr | input | 9 | Instruction fetch read address |
| fetchData | output | 32 | Instruction fetch read data, one cycle after the address |
| srcAddr | input | 9 | Source operand read address |
| srcData | output | 32 | Source operand read data, one cycle after the address |
| dstAddr | input | 9 | Destination operand read address |
| dstData | output | 32 | Destination operand read data, one cycle after the address |

## Verification
The properties assume that all inputs are driven to known values on every clock edge after reset, since the bypass and coherence checks compare addresses and would be meaningless with unknown bits; the bench therefore drives every address, data and enable input to defined values from time zero. They also assume reset is held for at least one edge so that the sweep counter starts from zero, which the bench does with several reset cycles. The random phase confines most addresses to a small window so that port-to-port and read-to-write address collisions happen often, and it periodically forces all three read ports onto the same word.

// File: rtl/rf_pkg.sv
package rf_pkg;

  // number of independent read ports (fetch, source, destination)
  localparam int RD_PORTS = 3;

  // strobes from control to datapath
  typedef struct packed {
    logic                bankWe;    // write all copies this cycle
    logic                zeroFill;  // write zero instead of the external data
    logic [RD_PORTS-1:0] bypass;    // registered: output the last write data
  } rf_strobe_t;

endpackage

// File: rtl/rf_bank.sv
module rf_bank #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             we,
  input  logic [AW-1:0]    wAddr,
  input  logic [WIDTH-1:0] wData,
  input  logic [AW-1:0]    rAddr,
  output logic [WIDTH-1:0] rData
);

  logic [WIDTH-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[wAddr] <= wData;
    rData <= mem[rAddr];
  end

endmodule

// File: rtl/rf_ctrl.sv
module rf_ctrl
  import rf_pkg::*;
#(
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        wrEn,
  input  logic [AW-1:0]               wrAddr,
  input  logic [RD_PORTS-1:0][AW-1:0] rdAddr,
  output rf_strobe_t                  strobe,
  output logic [AW-1:0]               bankAddr,
  output logic                        ready
);

  localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);

  logic [AW-1:0]       sweepIdx;
  logic [RD_PORTS-1:0] bypassQ;
  logic                effWe;

  always_comb begin
    effWe    = ready ? wrEn : 1'b1;
    bankAddr = ready ? wrAddr : sweepIdx;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sweepIdx <= '0;
      ready    <= 1'b0;
    end else if (!ready) begin
      sweepIdx <= sweepIdx + 1'b1;
      if (sweepIdx == LAST_IDX) ready <= 1'b1;
    end
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_byp
    always_ff @(posedge clk) begin
      if (!rstN) bypassQ[p] <= 1'b0;
      else       bypassQ[p] <= effWe && (bankAddr == rdAddr[p]);
    end
  end

  always_comb begin
    strobe.bankWe   = effWe;
    strobe.zeroFill = !ready;
    strobe.bypass   = bypassQ;
  end

endmodule

// File: rtl/rf_datapath.sv
module rf_datapath
  import rf_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                           clk,
  input  rf_strobe_t                     strobe,
  input  logic [AW-1:0]                  bankAddr,
  input  logic [WIDTH-1:0]               wrData,
  input  logic [RD_PORTS-1:0][AW-1:0]    rdAddr,
  output logic [RD_PORTS-1:0][WIDTH-1:0] rdData
);

  logic [WIDTH-1:0]                 fillData;
  logic [WIDTH-1:0]                 lastWrite;
  logic [RD_PORTS-1:0][WIDTH-1:0]   bankQ;

  assign fillData = strobe.zeroFill ? '0 : wrData;

  always_ff @(posedge clk) begin
    lastWrite <= fillData;
  end

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_copy
    rf_bank #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_bank (
      .clk   (clk),
      .we    (strobe.bankWe),
      .wAddr (bankAddr),
      .wData (fillData),
      .rAddr (rdAddr[p]),
      .rData (bankQ[p])
    );
    assign rdData[p] = strobe.bypass[p] ? lastWrite : bankQ[p];
  end

endmodule

// File: rtl/rf_tri_read.sv
module rf_tri_read
  import rf_pkg::*;
#(
  parameter int WIDTH = 32,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic             clk,
  input  logic             rstN,
  output logic             ready,
  input  logic             wrEn,
  input  logic [AW-1:0]    wrAddr,
  input  logic [WIDTH-1:0] wrData,
  input  logic [AW-1:0]    fetchAddr,
  output logic [WIDTH-1:0] fetchData,
  input  logic [AW-1:0]    srcAddr,
  output logic [WIDTH-1:0] srcData,
  input  logic [AW-1:0]    dstAddr,
  output logic [WIDTH-1:0] dstData
);

  rf_strobe_t                     strobe;
  logic [AW-1:0]                  bankAddr;
  logic [RD_PORTS-1:0][AW-1:0]    rdAddr;
  logic [RD_PORTS-1:0][WIDTH-1:0] rdData;

  assign rdAddr    = {dstAddr, srcAddr, fetchAddr};
  assign fetchData = rdData[0];
  assign srcData   = rdData[1];
  assign dstData   = rdData[2];

  rf_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .wrEn     (wrEn),
    .wrAddr   (wrAddr),
    .rdAddr   (rdAddr),
    .strobe   (strobe),
    .bankAddr (bankAddr),
    .ready    (ready)
  );

  rf_datapath #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_dp (
    .clk      (clk),
    .strobe   (strobe),
    .bankAddr (bankAddr),
    .wrData   (wrData),
    .rdAddr   (rdAddr),
    .rdData   (rdData)
  );

endmodule

// File: rtl/rf_tri_read_chk.sv
module rf_tri_read_chk #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 512,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic             clk,
  input logic             rstN,
  input logic             ready,
  input logic             wrEn,
  input logic [AW-1:0]    wrAddr,
  input logic [WIDTH-1:0] wrData,
  input logic [AW-1:0]    fetchAddr,
  input logic [WIDTH-1:0] fetchData,
  input logic [AW-1:0]    srcAddr,
  input logic [WIDTH-1:0] srcData,
  input logic [AW-1:0]    dstAddr,
  input logic [WIDTH-1:0] dstData
);

  localparam logic [CW-1:0] FULL = CW'(DEPTH);

  // edges seen since reset release, saturating at DEPTH
  logic [CW-1:0] edgeCnt;
  always_ff @(posedge clk) begin
    if (!rstN)               edgeCnt <= '0;
    else if (edgeCnt != FULL) edgeCnt <= edgeCnt + 1'b1;
  end

  assert_ready_timing_R1: assert property (@(posedge clk) disable iff (!rstN)
    ready == (edgeCnt == FULL));

  assert_ready_hold_R1: assert property (@(posedge clk) disable iff (!rstN)
    ready |=> ready);

  assert_bypass_fetch_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ready && wrEn && wrAddr == fetchAddr) |=> fetchData == $past(wrData));

  assert_bypass_src_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ready && wrEn && wrAddr == srcAddr) |=> srcData == $past(wrData));

  assert_bypass_dst_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ready && wrEn && wrAddr == dstAddr) |=> dstData == $past(wrData));

  assert_coherent_fs_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ready && fetchAddr == srcAddr) |=> fetchData == srcData);

  assert_coherent_sd_R9: assert property (@(posedge clk) disable iff (!rstN)
    (ready && srcAddr == dstAddr) |=> srcData == dstData);

endmodule

bind rf_tri_read rf_tri_read_chk #(.WIDTH(WIDTH), .DEPTH(DEPTH)) u_chk (
  .clk       (clk),
  .rstN      (rstN),
  .ready     (ready),
  .wrEn      (wrEn),
  .wrAddr    (wrAddr),
  .wrData    (wrData),
  .fetchAddr (fetchAddr),
  .fetchData (fetchData),
  .srcAddr   (srcAddr),
  .srcData   (srcData),
  .dstAddr   (dstAddr),
  .dstData   (dstData)
);

// File: tb/rf_tri_read_test.sv
module rf_tri_read_test;

  localparam int WIDTH = 32;
  localparam int DEPTH = 512;
  localparam int AW    = 9;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic             ready;
  logic             wrEn = 1'b0;
  logic [AW-1:0]    wrAddr = '0;
  logic [WIDTH-1:0] wrData = '0;
  logic [AW-1:0]    fetchAddr = '0, srcAddr = '0, dstAddr = '0;
  logic [WIDTH-1:0] fetchData, srcData, dstData;

  always #2 clk = ~clk;  // 250 MHz

  rf_tri_read #(.WIDTH(WIDTH), .DEPTH(DEPTH)) uut (.*);

  typedef struct {
    logic [WIDTH-1:0] exp [3];
    string            tag;
  } item_t;

  item_t            sbQueue [$];
  logic [WIDTH-1:0] model [DEPTH];
  int checks = 0;
  int failures = 0;
  bit finished = 0;

  task automatic checkVal(string tag, string what, logic [WIDTH-1:0] act, logic [WIDTH-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // driver: one cycle of stimulus, expected outputs go to the scoreboard
  task automatic drive(logic [AW-1:0] fa, logic [AW-1:0] sa, logic [AW-1:0] da,
                       logic we, logic [AW-1:0] wa, logic [WIDTH-1:0] wd, string tag);
    item_t it;
    logic [AW-1:0] ra [3];
    @(negedge clk);
    fetchAddr = fa; srcAddr = sa; dstAddr = da;
    wrEn = we; wrAddr = wa; wrData = wd;
    ra[0] = fa; ra[1] = sa; ra[2] = da;
    for (int p = 0; p < 3; p++)
      it.exp[p] = (we && wa == ra[p]) ? wd : model[ra[p]];
    it.tag = tag;
    sbQueue.push_back(it);
    if (we) model[wa] = wd;
  endtask

  // monitor: compares after each rising edge
  initial begin
    item_t it;
    forever begin
      @(posedge clk);
      #1;
      if (sbQueue.size() > 0) begin
        it = sbQueue.pop_front();
        checkVal(it.tag, "fetchData", fetchData, it.exp[0]);
        checkVal(it.tag, "srcData",   srcData,   it.exp[1]);
        checkVal(it.tag, "dstData",   dstData,   it.exp[2]);
      end
    end
  end

  task automatic finish();
    if (!finished) begin
      finished = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    #(4 * 200000);
    failures++;
    $display("FAIL watchdog timeout");
    finish();
  end

  initial begin
    int edges;
    for (int i = 0; i < DEPTH; i++) model[i] = '0;

    // R1: reset state
    repeat (3) @(negedge clk);
    checkVal("R1", "ready in reset", {31'b0, ready}, 32'd0);

    // release reset; R3: external writes during the sweep must be discarded
    @(negedge clk);
    rstN = 1'b1;
    wrEn = 1'b1; wrAddr = 9'd5; wrData = 32'hDEAD_BEEF;
    edges = 0;
    while (!ready && edges < 2 * DEPTH) begin
      @(posedge clk);
      #1;
      edges++;
      if (edges == 2) wrAddr = 9'd511;
    end
    checkVal("R1", "edges until ready", edges, DEPTH);
    @(negedge clk);
    wrEn = 1'b0;
    checkVal("R1", "ready stays high", {31'b0, ready}, 32'd1);

    // R2/R3: untouched and sweep-time-written words read zero
    drive(9'd5, 9'd511, 9'd0, 1'b0, 9'd0, 32'd0, "R3");
    drive(9'd100, 9'd200, 9'd300, 1'b0, 9'd0, 32'd0, "R2");

    // R4: store then read back on each port
    drive(9'd0, 9'd0, 9'd0, 1'b1, 9'd10, 32'h1111_0010, "R4");
    drive(9'd0, 9'd0, 9'd0, 1'b1, 9'd20, 32'h2222_0020, "R4");
    drive(9'd0, 9'd0, 9'd0, 1'b1, 9'd511, 32'hFFFF_01FF, "R4");
    drive(9'd10, 9'd20, 9'd511, 1'b0, 9'd0, 32'd0, "R4");
    // R6: distinct words on three ports, rotated
    drive(9'd511, 9'd10, 9'd20, 1'b0, 9'd0, 32'd0, "R6");
    // R5: back-to-back address changes give one-cycle latency
    drive(9'd20, 9'd511, 9'd10, 1'b0, 9'd0, 32'd0, "R5");
    drive(9'd10, 9'd10, 9'd0, 1'b0, 9'd0, 32'd0, "R5");

    // R7: same-cycle bypass on each port
    drive(9'd30, 9'd0, 9'd0, 1'b1, 9'd30, 32'hAAAA_0030, "R7");
    drive(9'd0, 9'd31, 9'd0, 1'b1, 9'd31, 32'hBBBB_0031, "R7");
    drive(9'd0, 9'd0, 9'd32, 1'b1, 9'd32, 32'hCCCC_0032, "R7");
    drive(9'd10, 9'd10, 9'd10, 1'b1, 9'd10, 32'h5555_AAAA, "R7");

    // R8: disabled write changes nothing, even reading the same word
    drive(9'd10, 9'd20, 9'd30, 1'b0, 9'd10, 32'h0BAD_0BAD, "R8");
    drive(9'd10, 9'd20, 9'd30, 1'b0, 9'd0, 32'd0, "R8");

    // R9: random traffic with frequent collisions, all ports same word now and then
    for (int n = 0; n < 3000; n++) begin
      logic [AW-1:0] fa, sa, da, wa;
      logic we;
      fa = (n % 7 == 0) ? AW'($urandom) : AW'($urandom_range(0, 15));
      sa = AW'($urandom_range(0, 15));
      da = AW'($urandom_range(0, 15));
      if (n % 5 == 0) begin sa = fa; da = fa; end
      wa = AW'($urandom_range(0, 15));
      we = ($urandom_range(0, 3) != 0);
      drive(fa, sa, da, we, wa, $urandom, "R9");
    end

    drive(9'd0, 9'd0, 9'd0, 1'b0, 9'd0, 32'd0, "R9");
    repeat (3) @(negedge clk);
    finish();
  end

endmodule